// File: doc/BRIEF.md
# PCM Transmit Slot Formatter

This block prepares one voice channel for a time-division serial highway. Once per frame it captures a 16-bit two's complement linear sample together with the channel's coding settings. It turns the sample into an 8-bit companded code, using either A-law or µ-law, or it keeps the full 16-bit linear word. It then shifts that code out, most significant bit first, in the time slot assigned to the channel.

The system clock is the bit clock: each rising edge advances the highway by one bit. A one-cycle frame sync pulse marks the start of every frame. A gain code of zero mutes the channel, which then sends the idle code of the selected coding. A power-down flag or reset keeps the output enable low, so the line is left undriven. The gain multiplication itself is done elsewhere; here the gain code is used only to detect mute.

Top module: `pcm_tx_slotter`

## Requirements
- R1: With `lin_mode`=0 and `alaw_sel`=0, the slot carries µ-law. Take `sample_in[15:2]` as a signed value. Its magnitude is clipped to 8158 and increased by 33. The segment is the position of the highest set bit minus 5. The mantissa is the four bits just below that bit. The code is {sign, segment[2:0], mantissa[3:0]} bit-inverted, where sign is 1 for negative samples.
- R2: With `lin_mode`=0 and `alaw_sel`=1, the slot carries A-law. Take `sample_in[15:3]` as a signed value. The magnitude is the value itself when positive and its ones' complement when negative. The segment is 0 below 32; otherwise it is the highest set bit minus 4. The mantissa is the magnitude shifted right by 1 in segment 0 and by the segment number otherwise, keeping 4 bits. The code is {0, segment, mantissa} XOR D5h for positive samples and XOR 55h for negative samples.
- R3: With `lin_mode`=1 the 16-bit sample is sent unchanged, MSB first, over two adjacent slots, 16 bits in all, starting at the assigned slot. `lin_mode` overrides `alaw_sel`.
- R4: When `gain_code` is 00h at frame sync, the idle code is sent with `dx_oe` still asserted: D5h for A-law, FFh for µ-law, 0000h for linear. Any other gain code, for example 8Fh or FFh, has no effect on the code.
- R5: Let edge E0 be the rising edge that samples `fsync` high. Frame bit b is registered at edge E(b+1). Slot s covers frame bits s*8 to s*8+7, MSB first. `dx_oe` is high only during the bits of the assigned window, and `dx_out` is 0 whenever `dx_oe` is low.
- R6: `sample_in`, `alaw_sel`, `lin_mode`, `gain_code` and `slot_sel` are captured at E0. Changes to them later in the frame do not affect that frame's output.
- R7: On each edge that samples `pwr_down` high, `dx_oe` and `dx_out` are registered low. The next frame transmits normally once `pwr_down` is low again.
- R8: Reset is synchronous and active high. It registers `dx_oe` and `dx_out` low. After reset nothing is sent until a frame sync arrives.
- R9: Frame bits at positions 8*NUM_SLOTS and beyond are never sent. A linear word in the last slot therefore sends only its upper byte. If no new frame sync arrives, the line stays idle.
- R10: A frame sync may arrive on the same edge that sends the last bit of the frame. That bit still goes out with the previous frame's data, and the new frame starts from bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit clock; one highway bit per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| fsync | input | 1 | One-cycle frame start pulse |
| sample_in | input | 16 | Linear two's complement sample |
| alaw_sel | input | 1 | 1 selects A-law, 0 selects µ-law |
| lin_mode | input | 1 | 1 sends the 16-bit linear word over two slots |
| gain_code | input | 8 | Transmit gain code; 00h mutes the channel |
| pwr_down | input | 1 | Channel power-down; disables the output |
| slot_sel | input | 5 | Assigned time slot number |
| dx_out | output | 1 | Serial data |
| dx_oe | output | 1 | Output enable for the serial data line |

## Verification
Two functions can land on the same edge. The first is a frame sync together with the last bit of the last slot. The bench provokes it by sending back-to-back frames in slot 31 spaced exactly one frame apart. The monitor then judges that bit against the previous frame's expected word and bit 0 of the new window against the new word. The second is a power-down that rises in the middle of a linear window. The monitor checks that the output enable drops on exactly the bit after the edge that samples the flag, while the earlier bits of the word went out intact.

// File: rtl/pcm_tx_pkg.sv
package pcm_tx_pkg;
  localparam int SAMPLE_W  = 16;
  localparam int CODE_W    = 8;
  localparam int MU_BIAS   = 33;
  localparam int MU_CLIP   = 8158;
  localparam logic [CODE_W-1:0] A_MASK_POS = 8'hD5;
  localparam logic [CODE_W-1:0] A_MASK_NEG = 8'h55;
  localparam logic [CODE_W-1:0] MU_IDLE    = 8'hFF;

  typedef enum logic {LAW_MU = 1'b0, LAW_A = 1'b1} law_e;

  typedef struct packed {
    logic [SAMPLE_W-1:0] sample;
    law_e                law;
    logic                lin;
    logic                mute;
  } frame_cfg_t;
endpackage

// File: rtl/pcm_frame_timer.sv
module pcm_frame_timer #(
  parameter int FRAME_BITS = 256,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fsync,
  output logic [CNT_W-1:0] bit_cnt
);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(FRAME_BITS);

  // Counter rests at CNT_END (no window can match) until a frame sync.
  always_ff @(posedge clk) begin
    if (rst)                   bit_cnt <= CNT_END;
    else if (fsync)            bit_cnt <= '0;
    else if (bit_cnt != CNT_END) bit_cnt <= bit_cnt + 1'b1;
  end

  a_r9_count_holds: assert property (@(posedge clk) disable iff (rst)
    (bit_cnt == CNT_END && !fsync) |=> bit_cnt == CNT_END);
  a_r10_fsync_restart: assert property (@(posedge clk) disable iff (rst)
    fsync |=> bit_cnt == '0);
endmodule

// File: rtl/pcm_g711_enc.sv
module pcm_g711_enc
  import pcm_tx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  frame_cfg_t        cfg,
  output logic [WORD_W-1:0] word
);
  function automatic logic [CODE_W-1:0] mu_code(input logic [13:0] x);
    logic        neg;
    logic [14:0] mag;
    logic [12:0] biased;
    logic [12:0] shifted;
    logic [2:0]  seg;
    neg = x[13];
    mag = neg ? (~{x[13], x} + 15'd1) : {x[13], x};
    if (mag > 15'(MU_CLIP)) mag = 15'(MU_CLIP);
    biased = 13'(mag + 15'(MU_BIAS));
    seg = 3'd0;
    for (int i = 0; i < 8; i++) if (biased[i+5]) seg = 3'(i);
    shifted = biased >> ({1'b0, seg} + 4'd1);
    return ~{neg, seg, shifted[3:0]};
  endfunction

  function automatic logic [CODE_W-1:0] a_code(input logic [12:0] x);
    logic        neg;
    logic [11:0] mag;
    logic [11:0] shifted;
    logic [2:0]  seg;
    neg = x[12];
    mag = neg ? ~x[11:0] : x[11:0];
    seg = 3'd0;
    for (int i = 1; i < 8; i++) if (mag[i+4]) seg = 3'(i);
    shifted = mag >> ((seg == 3'd0) ? 3'd1 : seg);
    return {1'b0, seg, shifted[3:0]} ^ (neg ? A_MASK_NEG : A_MASK_POS);
  endfunction

  logic [CODE_W-1:0] cmp_code;

  always_comb begin
    if (cfg.law == LAW_A) cmp_code = cfg.mute ? A_MASK_POS : a_code(cfg.sample[15:3]);
    else                  cmp_code = cfg.mute ? MU_IDLE    : mu_code(cfg.sample[15:2]);
  end

  // Companded codes are left-aligned so the shifter always starts at the MSB.
  assign word = cfg.lin ? (cfg.mute ? '0 : WORD_W'(cfg.sample))
                        : {cmp_code, {(WORD_W-CODE_W){1'b0}}};
endmodule

// File: rtl/pcm_slot_shifter.sv
module pcm_slot_shifter #(
  parameter int SLOT_W    = 8,
  parameter int NUM_SLOTS = 32,
  localparam int FRAME_BITS = NUM_SLOTS * SLOT_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1),
  localparam int WIN_W      = CNT_W + 1,
  localparam int WORD_W     = 2 * SLOT_W,
  localparam int IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pwr_down,
  input  logic [CNT_W-1:0]  bit_cnt,
  input  logic [IDX_W-1:0]  slot,
  input  logic              lin,
  input  logic [WORD_W-1:0] word,
  output logic              dx_out,
  output logic              dx_oe
);
  logic [WIN_W-1:0]  pos, win_start, win_end;
  logic              in_win, first, next_bit;
  logic [WORD_W-1:0] sr;

  always_comb begin
    pos       = {1'b0, bit_cnt};
    win_start = WIN_W'(slot) * WIN_W'(SLOT_W);
    win_end   = win_start + (lin ? WIN_W'(WORD_W) : WIN_W'(SLOT_W));
    in_win    = (pos >= win_start) && (pos < win_end) && (pos < WIN_W'(FRAME_BITS));
    first     = (pos == win_start);
    next_bit  = first ? word[WORD_W-1] : sr[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr     <= '0;
      dx_out <= 1'b0;
      dx_oe  <= 1'b0;
    end else begin
      if (in_win) sr <= first ? {word[WORD_W-2:0], 1'b0} : {sr[WORD_W-2:0], 1'b0};
      dx_oe  <= in_win && !pwr_down;
      dx_out <= in_win && !pwr_down && next_bit;
    end
  end

  a_r7_pd_quiet: assert property (@(posedge clk) disable iff (rst)
    pwr_down |=> (!dx_oe && !dx_out));
  a_r8_reset_quiet: assert property (@(posedge clk)
    rst |=> (!dx_oe && !dx_out));
  a_r5_idle_low: assert property (@(posedge clk) disable iff (rst)
    !dx_oe |-> !dx_out);
endmodule

// File: rtl/pcm_tx_slotter.sv
module pcm_tx_slotter
  import pcm_tx_pkg::*;
#(
  parameter int SLOT_W    = 8,
  parameter int NUM_SLOTS = 32,
  localparam int FRAME_BITS = NUM_SLOTS * SLOT_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 1),
  localparam int WORD_W     = 2 * SLOT_W,
  localparam int IDX_W      = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fsync,
  input  logic [SAMPLE_W-1:0] sample_in,
  input  logic                alaw_sel,
  input  logic                lin_mode,
  input  logic [7:0]          gain_code,
  input  logic                pwr_down,
  input  logic [IDX_W-1:0]    slot_sel,
  output logic                dx_out,
  output logic                dx_oe
);
  frame_cfg_t        hold_cfg;
  logic [IDX_W-1:0]  hold_slot;
  logic [CNT_W-1:0]  bit_cnt;
  logic [WORD_W-1:0] enc_word;

  // Per-frame capture: everything the frame needs is frozen at frame sync.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cfg  <= '0;
      hold_slot <= '0;
    end else if (fsync) begin
      hold_cfg.sample <= sample_in;
      hold_cfg.law    <= alaw_sel ? LAW_A : LAW_MU;
      hold_cfg.lin    <= lin_mode;
      hold_cfg.mute   <= (gain_code == 8'h00);
      hold_slot       <= slot_sel;
    end
  end

  pcm_frame_timer #(.FRAME_BITS(FRAME_BITS)) u_timer (
    .clk(clk), .rst(rst), .fsync(fsync), .bit_cnt(bit_cnt)
  );

  pcm_g711_enc #(.WORD_W(WORD_W)) u_enc (
    .cfg(hold_cfg), .word(enc_word)
  );

  pcm_slot_shifter #(.SLOT_W(SLOT_W), .NUM_SLOTS(NUM_SLOTS)) u_shift (
    .clk(clk), .rst(rst), .pwr_down(pwr_down), .bit_cnt(bit_cnt),
    .slot(hold_slot), .lin(hold_cfg.lin), .word(enc_word),
    .dx_out(dx_out), .dx_oe(dx_oe)
  );

  a_r6_hold_stable: assert property (@(posedge clk) disable iff (rst)
    !fsync |=> ($stable(hold_cfg) && $stable(hold_slot)));
  a_r4_idle_alaw: assert property (@(posedge clk) disable iff (rst)
    (hold_cfg.mute && hold_cfg.law == LAW_A && !hold_cfg.lin) |->
      enc_word[WORD_W-1 -: 8] == 8'hD5);
endmodule

// File: tb/pcm_tx_slotter_tb.sv
module pcm_tx_slotter_tb;
  localparam int SLOT_W     = 8;
  localparam int NUM_SLOTS  = 32;
  localparam int FRAME_BITS = SLOT_W * NUM_SLOTS;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        fsync = 1'b0;
  logic [15:0] sample_in = '0;
  logic        alaw_sel = 1'b0;
  logic        lin_mode = 1'b0;
  logic [7:0]  gain_code = 8'hFF;
  logic        pwr_down = 1'b0;
  logic [4:0]  slot_sel = '0;
  logic        dx_out, dx_oe;

  always #2 clk = ~clk;

  pcm_tx_slotter u_dut (
    .clk(clk), .rst(rst), .fsync(fsync), .sample_in(sample_in),
    .alaw_sel(alaw_sel), .lin_mode(lin_mode), .gain_code(gain_code),
    .pwr_down(pwr_down), .slot_sel(slot_sel), .dx_out(dx_out), .dx_oe(dx_oe)
  );

  typedef struct {
    bit        valid;
    bit [15:0] word;
    bit        lin;
    int        slot;
    string     req;
  } exp_t;

  exp_t q[$];
  exp_t cur, prev;
  int   k = 1000;
  bit   mon_en = 1'b0;
  bit   pd_seen = 1'b0;
  int   checks = 0;
  int   errors = 0;
  bit   done = 1'b0;

  function automatic logic [7:0] mu_ref(input logic [15:0] s);
    int v, m, seg, sgn;
    v = int'($signed(s)) >>> 2;
    sgn = (v < 0) ? 1 : 0;
    m = sgn ? -v : v;
    if (m > 8158) m = 8158;
    m = m + 33;
    seg = 0;
    while (seg < 7 && m >= (64 << seg)) seg++;
    return 8'(~((sgn << 7) | (seg << 4) | ((m >> (seg + 1)) & 15)));
  endfunction

  function automatic logic [7:0] a_ref(input logic [15:0] s);
    int v, m, seg, mant, mask;
    v = int'($signed(s)) >>> 3;
    if (v >= 0) begin mask = 'hD5; m = v; end
    else        begin mask = 'h55; m = -v - 1; end
    seg = 0;
    while (seg < 7 && m >= (32 << seg)) seg++;
    mant = (seg == 0) ? ((m >> 1) & 15) : ((m >> seg) & 15);
    return 8'(((seg << 4) | mant) ^ mask);
  endfunction

  function automatic bit win_oe(input exp_t r, input int p);
    int st;
    st = r.slot * SLOT_W;
    return r.valid && p >= st && p < st + (r.lin ? 2 * SLOT_W : SLOT_W) && p < FRAME_BITS;
  endfunction

  // Monitor: pops one expected frame per frame sync and judges every bit.
  always @(negedge clk) begin
    exp_t r;
    int   p;
    bit   eo, eb;
    string tag;
    if (mon_en) begin
      if (fsync) begin
        prev = cur;
        if (q.size() > 0) cur = q.pop_front();
        else begin cur.valid = 0; cur.req = "R8"; end
        k = 0;
      end else if (k < 1000) k++;
      p = k - 2;
      r = cur;
      if (p < 0) begin r = prev; p = p + FRAME_BITS; end
      eo  = win_oe(r, p) && !pd_seen;
      tag = (win_oe(r, p) && pd_seen) ? "R7" : (p >= FRAME_BITS ? "R9" : r.req);
      checks++;
      if (dx_oe !== eo) begin
        errors++;
        $display("FAIL %s oe at frame bit %0d: got %0b expected %0b", tag, p, dx_oe, eo);
      end
      checks++;
      eb = eo ? r.word[15 - (p - r.slot * SLOT_W)] : 1'b0;
      if (dx_out !== eb) begin
        errors++;
        $display("FAIL %s data at frame bit %0d: got %0b expected %0b", tag, p, dx_out, eb);
      end
    end
    pd_seen = pwr_down;
  end

  // Driver: called just after a rising edge; returns just after the edge
  // before the next frame sync should be sampled.
  task automatic send(input logic [15:0] smp, input bit al, input bit ln,
                      input logic [7:0] g, input int sl, input bit pd,
                      input int pd_mid, input int ncyc, input string req);
    exp_t e;
    sample_in = smp; alaw_sel = al; lin_mode = ln; gain_code = g;
    slot_sel = 5'(sl); pwr_down = pd; fsync = 1'b1;
    e.valid = 1; e.lin = ln; e.slot = sl; e.req = req;
    if (ln) e.word = (g == 8'h00) ? 16'h0000 : smp;
    else    e.word = {(g == 8'h00) ? (al ? 8'hD5 : 8'hFF) : (al ? a_ref(smp) : mu_ref(smp)), 8'h00};
    q.push_back(e);
    @(posedge clk); #1;
    // r6_: scramble every captured input after the capture edge
    fsync = 1'b0; sample_in = ~smp; alaw_sel = ~al; lin_mode = ~ln;
    gain_code = (g == 8'h00) ? 8'hFF : 8'h00; slot_sel = 5'(sl + 7);
    for (int c = 1; c < ncyc; c++) begin
      @(posedge clk); #1;
      if (c == pd_mid) pwr_down = 1'b1;
    end
  endtask

  task automatic quiet_check(input string what);
    checks++;
    if (dx_oe !== 1'b0 || dx_out !== 1'b0) begin
      errors++;
      $display("FAIL R8 %s: got oe=%0b out=%0b expected oe=0 out=0", what, dx_oe, dx_out);
    end
  endtask

  task automatic do_reset(input int hold);
    mon_en = 1'b0; q.delete(); fsync = 1'b0; pwr_down = 1'b0; rst = 1'b1;
    @(posedge clk); @(negedge clk);
    quiet_check("in reset");
    repeat (hold) @(posedge clk);
    #1 rst = 1'b0;
    for (int c = 0; c < 12; c++) begin
      @(negedge clk);
      quiet_check("before first frame sync");
    end
    @(posedge clk); #1;
    cur.valid = 0; cur.req = "R8"; prev = cur; k = 1000; mon_en = 1'b1;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got no end, expected end of stimulus");
    finish_run();
  end

  initial begin
    @(posedge clk); #1;
    do_reset(3);
    // R1: mu-law, several magnitudes, signs and slots
    send(16'h0000, 0, 0, 8'hFF, 0,  0, -1, FRAME_BITS, "R1");
    send(16'd1000, 0, 0, 8'h8F, 3,  0, -1, FRAME_BITS, "R1");
    send(16'hFC18, 0, 0, 8'hFF, 12, 0, -1, FRAME_BITS, "R1");
    send(16'h0123, 0, 0, 8'hFF, 1,  0, -1, FRAME_BITS, "R5");
    // R10: back-to-back frames in the last slot, sync meets the last bit
    send(16'h7FFF, 0, 0, 8'hFF, 31, 0, -1, FRAME_BITS, "R10");
    send(16'h8000, 0, 0, 8'hFF, 31, 0, -1, FRAME_BITS, "R10");
    // R2: A-law
    send(16'h0000, 1, 0, 8'hFF, 0,  0, -1, FRAME_BITS, "R2");
    send(16'h007B, 1, 0, 8'hFF, 2,  0, -1, FRAME_BITS, "R2");
    send(16'hFF84, 1, 0, 8'h8F, 30, 0, -1, FRAME_BITS, "R2");
    send(16'h7FFF, 1, 0, 8'hFF, 31, 0, -1, FRAME_BITS, "R10");
    send(16'h8000, 1, 0, 8'hFF, 31, 0, -1, FRAME_BITS, "R10");
    send(16'hFFFF, 1, 0, 8'hFF, 7,  0, -1, FRAME_BITS, "R2");
    // R3: linear over two slots
    send(16'h1234, 0, 1, 8'hFF, 5,  0, -1, FRAME_BITS, "R3");
    send(16'hA5C3, 1, 1, 8'hFF, 0,  0, -1, FRAME_BITS, "R3");
    // R9: linear word in the last slot keeps only its upper byte
    send(16'h8001, 0, 1, 8'hFF, 31, 0, -1, FRAME_BITS, "R9");
    // R4: mute gives idle codes
    send(16'h4321, 0, 0, 8'h00, 4,  0, -1, FRAME_BITS, "R4");
    send(16'h7FFF, 1, 0, 8'h00, 4,  0, -1, FRAME_BITS, "R4");
    send(16'hBEEF, 0, 1, 8'h00, 9,  0, -1, FRAME_BITS, "R4");
    // R6: capture at frame sync, inputs scrambled afterwards
    send(16'h4000, 1, 0, 8'h01, 6,  0, -1, FRAME_BITS, "R6");
    // R7: whole frame powered down, then power-down rising mid-window
    send(16'h2222, 0, 1, 8'hFF, 2,  1, -1, FRAME_BITS, "R7");
    send(16'h5A5A, 0, 1, 8'hFF, 10, 0, 86, FRAME_BITS, "R7");
    send(16'h1111, 0, 0, 8'hFF, 0,  0, -1, FRAME_BITS, "R7");
    // R8: reset in the middle of an active window
    send(16'hA5C3, 0, 1, 8'hFF, 0,  0, -1, 6, "R8");
    do_reset(2);
    send(16'h0F0F, 1, 0, 8'hFF, 0,  0, -1, FRAME_BITS, "R8");
    send(16'hC000, 0, 0, 8'hFF, 31, 0, -1, FRAME_BITS, "R10");
    // R9: no further sync, the line must stay idle
    repeat (FRAME_BITS + 8) @(posedge clk);
    finish_run();
  end
endmodule